// File: doc/BRIEF.md
# AES Column Mixing Unit (Forward and Inverse)

This block applies the AES column-mixing step, or its inverse, to one 128-bit cipher state per transfer. A single direction bit chosen with each transfer selects the operation. The inverse has no matrix of its own. A light pre-multiplication built from multiply-by-x² terms is applied to the state first, and the product then passes through the same forward mixing network. The two directions therefore share one set of column XOR trees.

The state enters through a valid/ready input port. The mixed result is captured in an output register and offered on a valid/ready output port. A single-entry skid register lets the input accept one more transfer while the output is stalled. Byte substitution, row rotation, key addition and round sequencing are handled by neighbouring logic.

Top module: `aes_mix_unit`

## Requirements
- R1: State byte i (i = 0..15) occupies bits [8i+7:8i]. Column c is made of bytes 4c, 4c+1, 4c+2 and 4c+3, in that row order.
- R2: With in_inv = 0, output byte i equals 2·a[i] ^ 3·a[j1] ^ a[j2] ^ a[j3], where jk = 4·(i/4) + ((i+k) mod 4). Multiplication is in GF(2^8) with reduction by 0x1B, so doubling is a left shift by one that is XORed with 0x1B when the old bit 7 was set.
- R3: With in_inv = 1, the output is the inverse column mixing of the input. Feeding a forward result back in with in_inv = 1 returns the original state.
- R4: A column holding bytes db, 13, 53, 45 (rows 0..3) maps forward to 8e, 4d, a1, bc. The inverse maps those bytes back.
- R5: Each column is transformed independently. A column of all-zero bytes gives zeros whatever the other columns hold, and the result does not depend on which column position holds the data.
- R6: A transfer accepted at a clock edge (in_valid and in_ready both high) makes out_valid high after that edge, with the result on out_data. While out_valid is high and out_ready is low, out_valid and out_data hold.
- R7: At most two results are held. in_ready is low exactly when two results wait. Results leave in the order they were accepted, with none lost or repeated.
- R8: A synchronous active-high reset empties the unit. After it, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input state offered |
| in_ready | output | 1 | Unit can take a state |
| in_data | input | 128 | Input state, byte i at bits [8i+7:8i] |
| in_inv | input | 1 | Direction: 0 forward, 1 inverse |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Mixed state |

## Verification
Fixed columns check the exact byte values of the forward and inverse transforms. The same column placed at the lowest and at the highest position exposes swapped byte lanes or columns that leak into each other. Random states sent forward and then fed back inverted catch a faulty pre-multiplication, because only an exact inverse restores every byte. Random valid, ready and direction patterns are compared each cycle against a queue model built on the 2/3/1/1 and 14/11/13/9 coefficient matrices, which separates stall, skid and ordering errors from arithmetic ones.

// File: rtl/aes_mix_pkg.sv
package aes_mix_pkg;

   localparam int BYTE_W   = 8;
   localparam int COL_ROWS = 4;

   typedef enum logic {
      DIR_FWD = 1'b0,
      DIR_INV = 1'b1
   } mix_dir_e;

   // multiply by x in GF(2^8), reducing with poly
   function automatic logic [7:0] gf_dbl(input logic [7:0] a, input logic [7:0] poly);
      return {a[6:0], 1'b0} ^ (a[7] ? poly : 8'h00);
   endfunction

   // multiply by x^2: two doublings
   function automatic logic [7:0] gf_quad(input logic [7:0] a, input logic [7:0] poly);
      return gf_dbl(gf_dbl(a, poly), poly);
   endfunction

endpackage

// File: rtl/aes_mix_pre.sv
module aes_mix_pre
   import aes_mix_pkg::*;
#(
   parameter int         N_COLS = 4,
   parameter logic [7:0] POLY   = 8'h1B,
   localparam int        NBYTES = N_COLS * COL_ROWS,
   localparam int        W      = NBYTES * BYTE_W
) (
   input  logic [W-1:0] state_i,
   output logic [W-1:0] state_o
);

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      localparam int PART = b ^ 2;   // row two away, same column
      logic [7:0] self_b, part_b;
      assign self_b = state_i[b*BYTE_W +: BYTE_W];
      assign part_b = state_i[PART*BYTE_W +: BYTE_W];
      assign state_o[b*BYTE_W +: BYTE_W] =
         gf_quad(self_b, POLY) ^ self_b ^ gf_quad(part_b, POLY);
   end

endmodule

// File: rtl/aes_mix_fwd.sv
module aes_mix_fwd
   import aes_mix_pkg::*;
#(
   parameter int         N_COLS = 4,
   parameter logic [7:0] POLY   = 8'h1B,
   localparam int        NBYTES = N_COLS * COL_ROWS,
   localparam int        W      = NBYTES * BYTE_W
) (
   input  logic [W-1:0] state_i,
   output logic [W-1:0] state_o
);

   for (genvar c = 0; c < N_COLS; c++) begin : g_col
      for (genvar r = 0; r < COL_ROWS; r++) begin : g_row
         localparam int I0 = c*COL_ROWS + r;
         localparam int I1 = c*COL_ROWS + ((r+1) % COL_ROWS);
         localparam int I2 = c*COL_ROWS + ((r+2) % COL_ROWS);
         localparam int I3 = c*COL_ROWS + ((r+3) % COL_ROWS);
         logic [7:0] a0, a1, a2, a3;
         assign a0 = state_i[I0*BYTE_W +: BYTE_W];
         assign a1 = state_i[I1*BYTE_W +: BYTE_W];
         assign a2 = state_i[I2*BYTE_W +: BYTE_W];
         assign a3 = state_i[I3*BYTE_W +: BYTE_W];
         assign state_o[I0*BYTE_W +: BYTE_W] =
            gf_dbl(a0, POLY) ^ gf_dbl(a1, POLY) ^ a1 ^ a2 ^ a3;
      end
   end

endmodule

// File: rtl/aes_mix_skid.sv
module aes_mix_skid #(
   parameter int W = 128
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);

   logic         out_v, skid_v;
   logic [W-1:0] out_q, skid_q;
   logic         accept, drain;

   assign in_ready  = !skid_v;
   assign accept    = in_valid && in_ready;
   assign drain     = !out_v || out_ready;
   assign out_valid = out_v;
   assign out_data  = out_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_v  <= 1'b0;
         skid_v <= 1'b0;
      end else if (drain) begin
         if (skid_v) begin
            out_v  <= 1'b1;
            skid_v <= 1'b0;
         end else begin
            out_v  <= accept;
         end
      end else if (accept) begin
         skid_v <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (drain) begin
         if (skid_v)      out_q <= skid_q;
         else if (accept) out_q <= in_data;
      end else if (accept) begin
         skid_q <= in_data;
      end
   end

   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
   p_fill_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid);
   p_skid_r7: assert property (@(posedge clk) disable iff (rst)
      !in_ready |-> out_valid);
   p_clear_r8: assert property (@(posedge clk)
      rst |=> !out_valid && in_ready);

endmodule

// File: rtl/aes_mix_unit.sv
module aes_mix_unit
   import aes_mix_pkg::*;
#(
   parameter int         N_COLS = 4,
   parameter logic [7:0] POLY   = 8'h1B,
   parameter bit         INV_EN = 1'b1,
   localparam int        W      = N_COLS * COL_ROWS * BYTE_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   input  logic         in_inv,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);

   if (N_COLS < 1) begin : g_bad_cols
      $error("aes_mix_unit: N_COLS must be at least 1");
   end
   if (POLY == 8'h00) begin : g_bad_poly
      $error("aes_mix_unit: POLY must be non-zero");
   end

   logic [W-1:0] fwd_in, mixed;

   if (INV_EN) begin : g_inv
      logic [W-1:0] pre_out;
      aes_mix_pre #(.N_COLS(N_COLS), .POLY(POLY)) u_pre (
         .state_i (in_data),
         .state_o (pre_out)
      );
      assign fwd_in = (mix_dir_e'(in_inv) == DIR_INV) ? pre_out : in_data;
   end else begin : g_fwd_only
      logic unused_inv;
      assign unused_inv = in_inv;
      assign fwd_in     = in_data;
   end

   aes_mix_fwd #(.N_COLS(N_COLS), .POLY(POLY)) u_fwd (
      .state_i (fwd_in),
      .state_o (mixed)
   );

   aes_mix_skid #(.W(W)) u_out (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (mixed),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
   );

   // Both directions keep the XOR of a column's bytes unchanged
   for (genvar c = 0; c < N_COLS; c++) begin : g_par
      localparam int CW = COL_ROWS * BYTE_W;
      logic [7:0] p_in, p_out;
      always_comb begin
         p_in  = '0;
         p_out = '0;
         for (int r = 0; r < COL_ROWS; r++) begin
            p_in  ^= in_data[c*CW + r*BYTE_W +: BYTE_W];
            p_out ^= mixed[c*CW + r*BYTE_W +: BYTE_W];
         end
      end
      p_colsum_r5: assert property (@(posedge clk) disable iff (rst)
         in_valid && in_ready |-> p_out == p_in);
   end

endmodule

// File: tb/tb_aes_mix_unit.sv
`timescale 1ns/1ps
module tb_aes_mix_unit;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_data = '0;
   logic         in_inv = 1'b0;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic [127:0] out_data;

   int n_run = 0;
   int n_fail = 0;
   logic [127:0] exp_q[$];
   logic [127:0] last_out;

   always #5 clk = ~clk;

   aes_mix_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_inv(in_inv), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p = 8'h00;
      logic [7:0] x = a;
      for (int k = 0; k < 8; k++) begin
         if (b[k]) p ^= x;
         x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
      end
      return p;
   endfunction

   function automatic logic [127:0] ref_mix(input logic [127:0] s, input logic inv);
      logic [7:0] cf [4];
      logic [127:0] o = '0;
      if (inv) begin cf[0]=8'd14; cf[1]=8'd11; cf[2]=8'd13; cf[3]=8'd9; end
      else     begin cf[0]=8'd2;  cf[1]=8'd3;  cf[2]=8'd1;  cf[3]=8'd1; end
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++) begin
            logic [7:0] acc = 8'h00;
            for (int k = 0; k < 4; k++)
               acc ^= gmul(cf[(k - r + 4) % 4], s[(c*4+k)*8 +: 8]);
            o[(c*4+r)*8 +: 8] = acc;
         end
      return o;
   endfunction

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // one cycle: drive, then compare against the queue model before the edge
   task automatic step(input logic v, input logic [127:0] d, input logic inv,
                       input logic rdy);
      @(negedge clk);
      in_valid = v; in_data = d; in_inv = inv; out_ready = rdy;
      #1;
      check(out_valid === (exp_q.size() > 0), "R7 out_valid", 128'(out_valid),
            128'(exp_q.size() > 0));
      check(in_ready === (exp_q.size() < 2), "R7 in_ready", 128'(in_ready),
            128'(exp_q.size() < 2));
      if (out_valid && out_ready && exp_q.size() > 0) begin
         logic [127:0] e = exp_q.pop_front();
         last_out = out_data;
         check(out_data === e, "R2/R3/R6 out_data", out_data, e);
      end
      if (in_valid && in_ready) exp_q.push_back(ref_mix(d, inv));
   endtask

   task automatic xfer(input logic [127:0] d, input logic inv, output logic [127:0] r);
      step(1'b1, d, inv, 1'b1);
      step(1'b0, '0, 1'b0, 1'b1);
      r = last_out;
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [127:0] r, f, g;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      check(out_valid === 1'b0 && in_ready === 1'b1, "R8 reset state",
            {out_valid, in_ready}, 128'b01);

      // R4/R1: known column in lowest position
      xfer({96'h0, 32'h455313db}, 1'b0, r);
      check(r === {96'h0, 32'hbca14d8e}, "R4 fwd col0", r, {96'h0, 32'hbca14d8e});
      xfer({96'h0, 32'hbca14d8e}, 1'b1, r);
      check(r === {96'h0, 32'h455313db}, "R4 inv col0", r, {96'h0, 32'h455313db});
      // R5/R1: same column at highest position
      xfer({32'h455313db, 96'h0}, 1'b0, r);
      check(r === {32'hbca14d8e, 96'h0}, "R5 fwd col3", r, {32'hbca14d8e, 96'h0});
      xfer({32'hbca14d8e, 96'h0}, 1'b1, r);
      check(r === {32'h455313db, 96'h0}, "R5 inv col3", r, {32'h455313db, 96'h0});
      // R2: column of equal bytes is unchanged
      xfer({4{32'h01010101}}, 1'b0, r);
      check(r === {4{32'h01010101}}, "R2 equal bytes", r, {4{32'h01010101}});

      // R3: round trip on random states
      for (int t = 0; t < 40; t++) begin
         f = rnd128();
         xfer(f, 1'b0, g);
         xfer(g, 1'b1, r);
         check(r === f, "R3 round trip", r, f);
      end

      // R6/R7: random valid/ready/direction traffic against the queue model
      for (int t = 0; t < 4000; t++)
         step($urandom_range(0, 3) != 0, rnd128(), 1'($urandom),
              $urandom_range(0, 2) != 0);
      // fill both entries with output stalled
      step(1'b1, rnd128(), 1'b0, 1'b0);
      step(1'b1, rnd128(), 1'b1, 1'b0);
      step(1'b1, rnd128(), 1'b0, 1'b0);
      check(in_ready === 1'b0, "R7 full blocks input", 128'(in_ready), 128'b0);
      for (int t = 0; t < 6; t++) step(1'b0, '0, 1'b0, 1'b1);

      // R8: reset with results pending
      step(1'b1, rnd128(), 1'b0, 1'b0);
      step(1'b1, rnd128(), 1'b0, 1'b0);
      @(negedge clk); rst = 1'b1; in_valid = 1'b0;
      @(negedge clk); rst = 1'b0;
      exp_q.delete();
      #1;
      check(out_valid === 1'b0 && in_ready === 1'b1, "R8 reset flush",
            {out_valid, in_ready}, 128'b01);
      for (int t = 0; t < 20; t++) step(1'b1, rnd128(), 1'($urandom), 1'b1);
      for (int t = 0; t < 4; t++) step(1'b0, '0, 1'b0, 1'b1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule